// File: doc/BRIEF.md
# Triplicated Serial Configuration Register

This block keeps the configuration word of a front-end chip. A controller loads the word one bit per clock over a serial input stream. Each frame carries the data bits, most significant first, and ends with one parity bit chosen so that the whole frame holds an even number of ones. When the load window closes, the frame is checked. A frame of the right length and parity is written into three identical storage copies in a single clock. Any other frame is dropped and a sticky error flag is raised.

The configuration the chip uses is the bitwise majority of the three copies, so one corrupted copy never reaches the configured circuits. On every clock, each copy is overwritten with the voted value, which repairs a single upset before a second can pile onto the same bit. Any disagreement seen raises a sticky mismatch flag. A readback stream sends the voted word back out, most significant bit first, so the controller can confirm the load.

Both streams use valid/ready. The input is accepted only while the load window is open: `sin_ready` follows `load_en`, and a bit is taken on every clock where `sin_valid` and `sin_ready` are both high. On the output, once `sout_valid` is high it stays high and `sout_data` stays stable until a clock where `sout_ready` is high. That clock completes the beat.

Top module: `cfg_tmr_reg`

## Requirements
- R1: While reset is low and after its release, all three copies hold `RST_VAL`, `cfg_o` equals `RST_VAL`, `frame_err` and `mismatch_err` are 0 and `sout_valid` is 0.
- R2: While `load_en` is high, each clock with `sin_valid` high shifts in one bit. The data bits arrive most significant first, and the parity bit is the last bit of the frame. Clocks with `sin_valid` low add no bit.
- R3: On the first clock where `load_en` is low after being high, a frame of exactly CFG_W+1 bits whose ones-count is even is written to all three copies. `cfg_o` shows the new word from the following cycle.
- R4: A frame with odd ones-count, or with a bit count other than CFG_W+1, is discarded. `cfg_o` keeps its value and `frame_err` goes to 1 the cycle after the window closes.
- R5: `cfg_o` is the bitwise majority of the three copies, so a flip in one copy does not change it.
- R6: On every clock, a copy that differs from the majority is rewritten with the voted value. `mismatch_err` goes to 1 the cycle after any difference is seen.
- R7: When a commit and a repair fall in the same clock, the commit wins: all three copies take the new frame.
- R8: A high `rb_req` while no readback is running snapshots the voted word. The word is then sent as exactly CFG_W beats, most significant bit first. Under back-pressure, data and valid hold. A `rb_req` during a readback is ignored.
- R9: With `load_en` low, `sin_ready` is 0 and bits offered on the input change nothing.
- R10: `frame_err` and `mismatch_err` stay at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Open load window; its falling edge closes the frame |
| sin_valid | input | 1 | Serial input bit valid |
| sin_ready | output | 1 | Serial input accepted (equals load window) |
| sin_data | input | 1 | Serial input bit |
| rb_req | input | 1 | Start a readback of the voted word |
| sout_valid | output | 1 | Readback bit valid |
| sout_ready | input | 1 | Readback consumer ready |
| sout_data | output | 1 | Readback bit |
| cfg_o | output | CFG_W | Voted configuration word |
| frame_err | output | 1 | Sticky bad-frame flag |
| mismatch_err | output | 1 | Sticky copy-disagreement flag |

## Verification
A commit and a per-clock repair can land in the same clock edge. The bench provokes this by flipping one bit of one copy in the same half-cycle where it lowers `load_en`. It then checks that `cfg_o` shows the new frame and that `mismatch_err` is raised. Finally, it flips the same bit in a second copy; `cfg_o` must still hold the new frame, which shows that the commit overwrote the first flip rather than the repair restoring the old word.

// File: rtl/cfg_tmr_pkg.sv
package cfg_tmr_pkg;
  localparam int unsigned NCOPY = 3;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx #(
  parameter int unsigned W = 220
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic         sin_valid,
  input  logic         sin_data,
  output logic         sin_ready,
  output logic         commit,
  output logic [W-1:0] frame_word,
  output logic         frame_err
);
  localparam int unsigned FW      = W + 1;
  localparam int unsigned CNT_MAX = W + 2;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic [FW-1:0]    sh;
  logic [CNT_W-1:0] cnt;
  logic             le_q;
  logic             eof;
  logic             good;

  assign sin_ready  = load_en;
  assign eof        = le_q & ~load_en;
  assign good       = (cnt == CNT_W'(FW)) & ~(^sh);
  assign commit     = eof & good;
  assign frame_word = sh[FW-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      cnt       <= '0;
      le_q      <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      le_q <= load_en;
      if (!load_en) begin
        cnt <= '0;
      end else if (sin_valid) begin
        sh <= {sh[FW-2:0], sin_data};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
      if (eof && !good) frame_err <= 1'b1;
    end
  end

  // R4: a rejected frame raises the error flag one cycle later
  a_r4_bad_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !good) |=> frame_err);

  // R10: the error flag only clears through reset
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  // R9: closed window accepts nothing, so the count cannot grow
  a_r9_closed_count: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> (cnt == '0));
endmodule

// File: rtl/cfg_tmr_store.sv
module cfg_tmr_store
  import cfg_tmr_pkg::*;
#(
  parameter int unsigned   W       = 220,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] voted,
  output logic         mis_flag
);
  logic [W-1:0] cp [NCOPY];
  logic         any_dis;

  always_comb begin
    for (int b = 0; b < W; b++) voted[b] = maj3(cp[0][b], cp[1][b], cp[2][b]);
  end

  for (genvar gi = 0; gi < NCOPY; gi++) begin : g_cp
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= RST_VAL;
      else if (commit) q <= wdata;
      else             q <= voted;
    end
    assign cp[gi] = q;
  end

  always_comb begin
    any_dis = 1'b0;
    for (int c = 0; c < NCOPY; c++) any_dis = any_dis | (|(cp[c] ^ voted));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mis_flag <= 1'b0;
    else        mis_flag <= mis_flag | any_dis;
  end

  // R6: a seen disagreement raises the flag on the next cycle
  a_r6_flag: assert property (@(posedge clk) disable iff (!rst_n)
    any_dis |=> mis_flag);

  // R10: mismatch flag is sticky
  a_r10_mis_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mis_flag |=> mis_flag);

  // R3 / R7: a commit lands in the voted word, overriding any repair
  a_r7_commit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (voted == $past(wdata)));

  // R5: without a commit the voted word does not move
  a_r5_vote_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(voted));
endmodule

// File: rtl/cfg_readback.sv
module cfg_readback #(
  parameter int unsigned W = 220
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rb_req,
  input  logic [W-1:0] snap,
  output logic         sout_valid,
  input  logic         sout_ready,
  output logic         sout_data
);
  localparam int unsigned LW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [LW-1:0] left;

  assign sout_valid = (left != '0);
  assign sout_data  = sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (left == '0) begin
      if (rb_req) begin
        sh   <= snap;
        left <= LW'(W);
      end
    end else if (sout_ready) begin
      sh   <= sh << 1;
      left <= left - 1'b1;
    end
  end

  // R8: back-pressure holds valid and data
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sout_valid && !sout_ready) |=> (sout_valid && $stable(sout_data)));

  // R8: an idle request starts a stream on the next cycle
  a_r8_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!sout_valid && rb_req) |=> sout_valid);
endmodule

// File: rtl/cfg_tmr_reg.sv
module cfg_tmr_reg #(
  parameter int unsigned        CFG_W   = 220,
  parameter logic [CFG_W-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             sin_valid,
  output logic             sin_ready,
  input  logic             sin_data,
  input  logic             rb_req,
  output logic             sout_valid,
  input  logic             sout_ready,
  output logic             sout_data,
  output logic [CFG_W-1:0] cfg_o,
  output logic             frame_err,
  output logic             mismatch_err
);
  logic             commit;
  logic [CFG_W-1:0] frame_word;

  cfg_frame_rx #(.W(CFG_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .sin_valid  (sin_valid),
    .sin_data   (sin_data),
    .sin_ready  (sin_ready),
    .commit     (commit),
    .frame_word (frame_word),
    .frame_err  (frame_err)
  );

  cfg_tmr_store #(.W(CFG_W), .RST_VAL(RST_VAL)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .wdata    (frame_word),
    .voted    (cfg_o),
    .mis_flag (mismatch_err)
  );

  cfg_readback #(.W(CFG_W)) u_rb (
    .clk        (clk),
    .rst_n      (rst_n),
    .rb_req     (rb_req),
    .snap       (cfg_o),
    .sout_valid (sout_valid),
    .sout_ready (sout_ready),
    .sout_data  (sout_data)
  );
endmodule

// File: tb/cfg_tmr_reg_tb.sv
module cfg_tmr_reg_tb;
  localparam int unsigned CW = 12;
  localparam logic [CW-1:0] RV = 12'hA5C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_en = 1'b0, sin_valid = 1'b0, sin_data = 1'b0;
  logic rb_req = 1'b0, sout_ready = 1'b0;
  logic sin_ready, sout_valid, sout_data, frame_err, mismatch_err;
  logic [CW-1:0] cfg_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [CW-1:0] cur;

  always #5 clk = ~clk;

  cfg_tmr_reg #(.CFG_W(CW), .RST_VAL(RV)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .sin_valid(sin_valid),
    .sin_ready(sin_ready), .sin_data(sin_data), .rb_req(rb_req),
    .sout_valid(sout_valid), .sout_ready(sout_ready), .sout_data(sout_data),
    .cfg_o(cfg_o), .frame_err(frame_err), .mismatch_err(mismatch_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; load_en = 1'b0; sin_valid = 1'b0; rb_req = 1'b0; sout_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cur = RV;
  endtask

  task automatic upset(input int k, input logic [CW-1:0] v);
    case (k)
      0: begin force u_dut.u_store.g_cp[0].q = v; release u_dut.u_store.g_cp[0].q; end
      1: begin force u_dut.u_store.g_cp[1].q = v; release u_dut.u_store.g_cp[1].q; end
      default: begin force u_dut.u_store.g_cp[2].q = v; release u_dut.u_store.g_cp[2].q; end
    endcase
  endtask

  // delta: -1 drops the parity bit, +1 appends one extra zero bit
  task automatic send(input logic [CW-1:0] w, input bit bad_par, input int delta,
                      input bit bubble, input bit hit_commit);
    logic [CW+1:0] fr;
    fr = {w, (^w) ^ bad_par, 1'b0};
    for (int j = 0; j < CW + 1 + delta; j++) begin
      @(negedge clk);
      load_en = 1'b1;
      if (bubble && j == 4) begin
        sin_valid = 1'b0;
        @(negedge clk);
      end
      sin_valid = 1'b1;
      sin_data = fr[CW+1-j];
    end
    @(negedge clk);
    load_en = 1'b0; sin_valid = 1'b0;
    if (hit_commit) upset(0, cfg_o ^ 12'h008);
    @(negedge clk);
  endtask

  task automatic readback(input logic [CW-1:0] exp, input bit poke);
    logic [CW-1:0] got;
    int n, t;
    bit pv, pd, held;
    got = '0; n = 0; t = 0; pv = 1'b0; pd = 1'b0; held = 1'b1;
    @(negedge clk); rb_req = 1'b1;
    @(negedge clk); rb_req = 1'b0;
    while (n < CW && t < 200) begin
      sout_ready = ((t % 3) != 1);
      if (poke && t == 5) rb_req = 1'b1; else rb_req = 1'b0;
      #1;
      if (pv && !(sout_valid && sout_data == pd)) held = 1'b0;
      if (sout_valid && sout_ready) begin got = {got[CW-2:0], sout_data}; n++; pv = 1'b0; end
      else begin pv = sout_valid; pd = sout_data; end
      @(negedge clk);
      t++;
    end
    rb_req = 1'b0; sout_ready = 1'b1;
    chk(got == exp, "R8 readback word", got, exp);
    chk(held, "R8 back-pressure hold", held, 1);
    #1 chk(!sout_valid, "R8 exact beat count", sout_valid, 0);
    sout_ready = 1'b0;
  endtask

  initial begin
    logic [CW-1:0] w;
    do_reset();
    #1;
    chk(cfg_o == RV, "R1 reset word", cfg_o, RV);
    chk(!frame_err && !mismatch_err, "R1 reset flags", {frame_err, mismatch_err}, 0);
    chk(!sout_valid, "R1 no readback", sout_valid, 0);
    readback(RV, 1'b0);

    // R2 R3: sweep of words, with and without bubbles
    for (int i = 0; i < 40; i++) begin
      w = CW'((i * 32'h9E3 + 32'h135) ^ (i << 7));
      if (i == 0) w = '0;
      if (i == 1) w = '1;
      send(w, 1'b0, 0, (i % 4) == 2, 1'b0);
      cur = w;
      #1 chk(cfg_o == w, "R3 commit", cfg_o, w);
      if (i % 5 == 0) readback(w, i == 10);
    end
    chk(!frame_err && !mismatch_err, "R2 good frames raise no flag", {frame_err, mismatch_err}, 0);

    // R9: closed window
    for (int j = 0; j < 6; j++) begin
      @(negedge clk); sin_valid = 1'b1; sin_data = j[0];
      #1 chk(!sin_ready, "R9 not ready when closed", sin_ready, 0);
    end
    @(negedge clk); sin_valid = 1'b0;
    #1 chk(cfg_o == cur, "R9 closed bits ignored", cfg_o, cur);

    // R4: bad parity, short and long frames
    for (int i = 0; i < 12; i++) begin
      w = CW'(i * 32'h3A7 + 1);
      send(w, (i % 3) == 0, (i % 3 == 1) ? -1 : ((i % 3 == 2) ? 1 : 0), 1'b0, 1'b0);
      #1 chk(cfg_o == cur, "R4 bad frame discarded", cfg_o, cur);
      chk(frame_err, "R4 frame_err set", frame_err, 1);
    end
    send(12'h3C5, 1'b0, 0, 1'b0, 1'b0);
    cur = 12'h3C5;
    #1 chk(cfg_o == cur, "R4 good frame after bad", cfg_o, cur);
    chk(frame_err, "R10 frame_err sticky", frame_err, 1);

    // R5 R6: single upsets on every bit of every copy
    do_reset();
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < CW; b++) begin
        @(negedge clk);
        upset(k, cur ^ (CW'(1) << b));
        #1 chk(cfg_o == cur, "R5 single upset masked", cfg_o, cur);
        @(negedge clk);
        chk(mismatch_err, "R6 mismatch flag", mismatch_err, 1);
        upset((k + 1) % 3, cur ^ (CW'(1) << b));
        #1 chk(cfg_o == cur, "R6 repaired copy", cfg_o, cur);
        @(negedge clk);
      end
    end
    chk(!frame_err, "R10 no cross flag", frame_err, 0);
    chk(mismatch_err, "R10 mismatch sticky", mismatch_err, 1);

    // R7: upset in the commit clock
    do_reset();
    send(12'h5E1, 1'b0, 0, 1'b0, 1'b1);
    #1 chk(cfg_o == 12'h5E1, "R7 commit wins", cfg_o, 12'h5E1);
    chk(mismatch_err, "R7 mismatch seen", mismatch_err, 1);
    @(negedge clk);
    upset(1, 12'h5E1 ^ 12'h008);
    #1 chk(cfg_o == 12'h5E1, "R7 copy overwritten by commit", cfg_o, 12'h5E1);
    @(negedge clk);
    readback(12'h5E1, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule